// File: doc/BRIEF.md
# Processor Bus Machine-Cycle Sequencer

This block turns one bus request from an 8-bit processor core into one external machine cycle, timed in T-states of one clock each. The requester presents a cycle kind, a 16-bit address, a write byte and, for opcode fetches, a requested state count. It does so while `busy` is low. The sequencer then runs the cycle on the external pins. It drives an address-latch strobe in the first state and active-low read or write strobes in the second and third states. An I/O-versus-memory select holds for the whole cycle, and the write byte is enabled onto the data bus.

For read-type cycles, the byte on the data input is captured at the clock edge that ends the third state. A one-clock `done` pulse follows the final T-state, with the captured byte available on `rdata`. Opcode fetches may add up to three internal states with no strobe activity, which gives a length of 4 to 6. Every other kind is exactly three states long.

Top module: `bus_cycle_seq`

## Requirements
- R1: While reset is held and after it is released with no request: `ale`=0, `rd_n`=1, `wr_n`=1, `io_m`=0, `data_oe`=0, `busy`=0, `done`=0.
- R2: A request is taken only on a clock edge where `req_valid`=1 and `busy`=0. A request presented while `busy`=1 does not alter the running cycle and is dropped if withdrawn before the sequencer goes idle.
- R3: `ale` is high exactly in T1, the clock after acceptance. `addr_out` equals the accepted address from T1 through the last T-state.
- R4: Kind codes are 0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write, 5 interrupt acknowledge. During a cycle `io_m` is 1 for codes 3, 4 and 5 and 0 for codes 0, 1 and 2.
- R5: `rd_n` is low in T2 and T3 for codes 0, 1, 3 and 5. `wr_n` is low in T2 and T3 for codes 2 and 4. Both are high in every other state, and they are never low together.
- R6: In write cycles `data_oe` is 1 in T2 and T3 only, with `data_out` equal to the accepted write byte. `data_oe` is 0 otherwise.
- R7: In read-type cycles (codes 0, 1, 3, 5) `rdata` takes the value of `data_in` sampled at the edge that ends T3. Values present before or after that edge have no effect.
- R8: Codes 1 to 5 last exactly 3 T-states. Code 0 lasts `req_fetch_len` states clamped into 4..6, so values 0 to 3 give 4 and 7 gives 6. `busy` is high for exactly that many clocks.
- R9: `done` is high for exactly one clock, the one right after the last T-state, and `busy` is 0 in that clock. A request held into that clock is accepted at its end.
- R10: States T4 to T6 of an opcode fetch assert no strobe: `ale`=0, `rd_n`=1, `wr_n`=1.
- R11: Kind codes 6 and 7 are not accepted. No cycle starts and `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one T-state |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 3 | Machine-cycle kind code |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Byte for write cycles |
| req_fetch_len | input | 3 | Requested opcode-fetch length in T-states |
| busy | output | 1 | A cycle is running; requests are not taken |
| done | output | 1 | One-clock pulse after the last T-state |
| rdata | output | 8 | Byte captured in the last read-type cycle |
| ale | output | 1 | Address latch strobe, high in T1 |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| io_m | output | 1 | 1 selects I/O space, 0 memory |
| addr_out | output | 16 | Address lines |
| data_out | output | 8 | Outgoing data byte |
| data_oe | output | 1 | Enable for the outgoing data byte |
| data_in | input | 8 | Incoming data byte |

## Verification
The assertions assume the requester holds its fields stable while `req_valid` is high. They also assume reset is released between clock edges. The strobe, select and length properties are stated only for accepted cycles, so rejected codes and requests made while busy never appear in the property antecedents. The bench drives every input half a period away from the sampling edge. It keeps `data_in` at a different value outside T3 so that a capture on the wrong edge shows up. It withdraws requests made during a cycle before that cycle finishes, unless a back-to-back start is the point of the test.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

   typedef enum logic [2:0] {
      CYC_FETCH = 3'd0,
      CYC_MRD   = 3'd1,
      CYC_MWR   = 3'd2,
      CYC_IORD  = 3'd3,
      CYC_IOWR  = 3'd4,
      CYC_INTA  = 3'd5
   } cyc_kind_e;

   function automatic logic kind_known(input logic [2:0] k);
      return k <= 3'd5;
   endfunction

   function automatic logic kind_reads(input cyc_kind_e k);
      return (k == CYC_FETCH) || (k == CYC_MRD) || (k == CYC_IORD) || (k == CYC_INTA);
   endfunction

   function automatic logic kind_writes(input cyc_kind_e k);
      return (k == CYC_MWR) || (k == CYC_IOWR);
   endfunction

   function automatic logic kind_io(input cyc_kind_e k);
      return (k == CYC_IORD) || (k == CYC_IOWR) || (k == CYC_INTA);
   endfunction

endpackage

// File: rtl/bcs_tstate_ctr.sv
module bcs_tstate_ctr
   import bcs_pkg::*;
#(
   parameter int LEN_W     = 3,
   parameter int BASE_LEN  = 3,
   parameter int MIN_FETCH = 4,
   parameter int MAX_FETCH = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  cyc_kind_e        start_kind,
   input  logic [LEN_W-1:0] start_len,
   output logic [LEN_W-1:0] tstate,
   output cyc_kind_e        kind_q,
   output logic             busy,
   output logic             last
);
   localparam logic [LEN_W-1:0] LEN_BASE = LEN_W'(BASE_LEN);
   localparam logic [LEN_W-1:0] LEN_MIN  = LEN_W'(MIN_FETCH);
   localparam logic [LEN_W-1:0] LEN_MAX  = LEN_W'(MAX_FETCH);

   if (MAX_FETCH >= (1 << LEN_W)) begin : g_bad_width
      $error("MAX_FETCH does not fit in LEN_W bits");
   end
   if (MIN_FETCH <= BASE_LEN || MIN_FETCH > MAX_FETCH) begin : g_bad_range
      $error("fetch length range must lie above BASE_LEN and be ordered");
   end

   logic [LEN_W-1:0] t_q;
   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] len_sel;

   always_comb begin
      if (start_kind != CYC_FETCH)      len_sel = LEN_BASE;
      else if (start_len < LEN_MIN)     len_sel = LEN_MIN;
      else if (start_len > LEN_MAX)     len_sel = LEN_MAX;
      else                              len_sel = start_len;
   end

   assign busy   = (t_q != '0);
   assign last   = busy && (t_q == len_q);
   assign tstate = t_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         t_q    <= '0;
         len_q  <= LEN_BASE;
         kind_q <= CYC_FETCH;
      end else if (start) begin
         t_q    <= LEN_W'(1);
         len_q  <= len_sel;
         kind_q <= start_kind;
      end else if (last) begin
         t_q    <= '0;
      end else if (busy) begin
         t_q    <= t_q + LEN_W'(1);
      end
   end
endmodule

// File: rtl/bcs_strobe_gen.sv
module bcs_strobe_gen
   import bcs_pkg::*;
#(
   parameter int LEN_W = 3
) (
   input  logic [LEN_W-1:0] tstate,
   input  cyc_kind_e        kind,
   input  logic             busy,
   output logic             ale,
   output logic             rd_n,
   output logic             wr_n,
   output logic             io_m,
   output logic             data_oe
);
   localparam logic [LEN_W-1:0] ST_T1 = LEN_W'(1);
   localparam logic [LEN_W-1:0] ST_T2 = LEN_W'(2);
   localparam logic [LEN_W-1:0] ST_T3 = LEN_W'(3);

   logic xfer_window;

   assign xfer_window = busy && ((tstate == ST_T2) || (tstate == ST_T3));

   always_comb begin
      ale     = busy && (tstate == ST_T1);
      rd_n    = !(xfer_window && kind_reads(kind));
      wr_n    = !(xfer_window && kind_writes(kind));
      data_oe = xfer_window && kind_writes(kind);
      io_m    = busy && kind_io(kind);
   end
endmodule

// File: rtl/bcs_bus_regs.sv
module bcs_bus_regs #(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter bit PARK_ADDR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              capture,
   input  logic              busy,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] wdata_in,
   input  logic [DATA_W-1:0] bus_in,
   output logic [ADDR_W-1:0] addr_out,
   output logic [DATA_W-1:0] data_out,
   output logic [DATA_W-1:0] rdata
);
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (start) begin
         addr_q  <= addr_in;
         wdata_q <= wdata_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rdata_q <= '0;
      else if (capture) rdata_q <= bus_in;
   end

   if (PARK_ADDR) begin : g_park
      assign addr_out = addr_q;
   end else begin : g_zero_idle
      assign addr_out = busy ? addr_q : '0;
   end

   assign data_out = wdata_q;
   assign rdata    = rdata_q;
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
   import bcs_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int LEN_W     = 3,
   parameter int BASE_LEN  = 3,
   parameter int MIN_FETCH = 4,
   parameter int MAX_FETCH = 6,
   parameter bit PARK_ADDR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LEN_W-1:0]  req_fetch_len,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic              ale,
   output logic              rd_n,
   output logic              wr_n,
   output logic              io_m,
   output logic [ADDR_W-1:0] addr_out,
   output logic [DATA_W-1:0] data_out,
   output logic              data_oe,
   input  logic [DATA_W-1:0] data_in
);
   localparam logic [LEN_W-1:0] ST_CAPTURE = LEN_W'(BASE_LEN);

   if (BASE_LEN != 3) begin : g_bad_base
      $error("the three-state transfer window needs BASE_LEN of 3");
   end

   logic             accept;
   logic             last;
   logic             capture;
   logic             done_q;
   logic [LEN_W-1:0] tstate;
   cyc_kind_e        kind_q;

   assign accept = req_valid && !busy && kind_known(req_kind);

   bcs_tstate_ctr #(
      .LEN_W(LEN_W), .BASE_LEN(BASE_LEN),
      .MIN_FETCH(MIN_FETCH), .MAX_FETCH(MAX_FETCH)
   ) u_ctr (
      .clk(clk), .rst_n(rst_n), .start(accept),
      .start_kind(cyc_kind_e'(req_kind)), .start_len(req_fetch_len),
      .tstate(tstate), .kind_q(kind_q), .busy(busy), .last(last)
   );

   bcs_strobe_gen #(.LEN_W(LEN_W)) u_strb (
      .tstate(tstate), .kind(kind_q), .busy(busy),
      .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m), .data_oe(data_oe)
   );

   assign capture = busy && (tstate == ST_CAPTURE) && kind_reads(kind_q);

   bcs_bus_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PARK_ADDR(PARK_ADDR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .start(accept), .capture(capture), .busy(busy),
      .addr_in(req_addr), .wdata_in(req_wdata), .bus_in(data_in),
      .addr_out(addr_out), .data_out(data_out), .rdata(rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done_q <= 1'b0;
      else        done_q <= last;
   end

   assign done = done_q;
endmodule

// File: rtl/bcs_chk.sv
module bcs_chk #(
   parameter int ADDR_W    = 16,
   parameter int MAX_FETCH = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [2:0]        req_kind,
   input logic              busy,
   input logic              done,
   input logic              ale,
   input logic              rd_n,
   input logic              wr_n,
   input logic              io_m,
   input logic              data_oe,
   input logic [ADDR_W-1:0] addr_out
);
   logic [7:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_len <= '0;
      else if (busy) run_len <= run_len + 8'd1;
      else           run_len <= '0;
   end

   // R5
   rd_wr_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n));

   // R3
   ale_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> $past(req_valid && !busy && (req_kind <= 3'd5)));

   // R3
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !ale) |-> $stable(addr_out));

   // R4
   io_m_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !ale) |-> $stable(io_m));

   // R5
   strobe_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n || !wr_n || ale) |-> busy);

   // R6
   oe_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe |-> !wr_n);

   // R9
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy) && !busy));

   // R9
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (run_len >= 8'd3 && run_len <= 8'(MAX_FETCH)));
endmodule

bind bus_cycle_seq bcs_chk #(.ADDR_W(ADDR_W), .MAX_FETCH(MAX_FETCH)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
   .busy(busy), .done(done), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
   .io_m(io_m), .data_oe(data_oe), .addr_out(addr_out)
);

// File: tb/sim_bus_cycle_seq.sv
module sim_bus_cycle_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_kind = '0;
   logic [15:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic [2:0]  req_fetch_len = '0;
   logic [7:0]  data_in = '0;
   logic        busy, done, ale, rd_n, wr_n, io_m, data_oe;
   logic [7:0]  rdata, data_out;
   logic [15:0] addr_out;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   bus_cycle_seq u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_fetch_len(req_fetch_len),
      .busy(busy), .done(done), .rdata(rdata), .ale(ale), .rd_n(rd_n),
      .wr_n(wr_n), .io_m(io_m), .addr_out(addr_out), .data_out(data_out),
      .data_oe(data_oe), .data_in(data_in)
   );

   typedef struct packed {
      logic [2:0]  kind;
      logic [15:0] addr;
      logic [7:0]  wd;
      logic [2:0]  flen;
      logic [7:0]  din;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{3'd0, 16'h0100, 8'h00, 3'd4, 8'h3E},
      '{3'd0, 16'h0101, 8'h00, 3'd6, 8'hC3},
      '{3'd0, 16'h0102, 8'h00, 3'd2, 8'h7A},
      '{3'd0, 16'h0103, 8'h00, 3'd7, 8'h11},
      '{3'd1, 16'h2050, 8'h00, 3'd5, 8'h9C},
      '{3'd2, 16'h3000, 8'h5A, 3'd6, 8'h00},
      '{3'd3, 16'h0042, 8'h00, 3'd4, 8'hE7},
      '{3'd4, 16'h0043, 8'hA6, 3'd4, 8'h00},
      '{3'd5, 16'hFFFF, 8'h00, 3'd4, 8'hCF}
   };

   function automatic bit m_rd(input logic [2:0] k);
      return k == 3'd0 || k == 3'd1 || k == 3'd3 || k == 3'd5;
   endfunction
   function automatic bit m_wr(input logic [2:0] k);
      return k == 3'd2 || k == 3'd4;
   endfunction
   function automatic bit m_io(input logic [2:0] k);
      return k == 3'd3 || k == 3'd4 || k == 3'd5;
   endfunction
   function automatic int m_len(input logic [2:0] k, input logic [2:0] f);
      if (k != 3'd0) return 3;
      if (f < 3'd4)  return 4;
      if (f > 3'd6)  return 6;
      return int'(f);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // packed status: {ale, rd_n, wr_n, io_m, data_oe, busy, done}
   function automatic logic [6:0] pins();
      return {ale, rd_n, wr_n, io_m, data_oe, busy, done};
   endfunction

   task automatic run_vec(input vec_t v);
      int len;
      bit xw;
      logic [6:0] e;
      len = m_len(v.kind, v.flen);
      @(negedge clk);
      req_valid = 1'b1; req_kind = v.kind; req_addr = v.addr;
      req_wdata = v.wd; req_fetch_len = v.flen; data_in = ~v.din;
      @(negedge clk);
      req_valid = 1'b0;
      for (int t = 1; t <= len; t++) begin
         if (t == 3) data_in = v.din;
         if (t == 4) data_in = ~v.din;
         xw = (t == 2 || t == 3);
         e = {t == 1, !(xw && m_rd(v.kind)), !(xw && m_wr(v.kind)),
              m_io(v.kind), xw && m_wr(v.kind), 1'b1, 1'b0};
         chk(pins() == e, "R3 R4 R5 R6 R10 strobes per T-state", 32'(pins()), 32'(e));
         chk(addr_out == v.addr, "R3 address held", 32'(addr_out), 32'(v.addr));
         if (xw && m_wr(v.kind))
            chk(data_out == v.wd, "R6 write byte", 32'(data_out), 32'(v.wd));
         @(negedge clk);
         if (t == 3) data_in = ~v.din;
      end
      chk(done && !busy, "R8 R9 done after last state", 32'({done, busy}), 32'h2);
      if (m_rd(v.kind))
         chk(rdata == v.din, "R7 capture at end of T3", 32'(rdata), 32'(v.din));
      @(negedge clk);
      chk(!done && !busy, "R9 done is one clock", 32'({done, busy}), 32'h0);
   endtask

   initial begin
      #(200000 * 10);
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(pins() == 7'b0110000, "R1 reset outputs", 32'(pins()), 32'h30);
      rst_n = 1'b1;
      @(negedge clk);
      chk(pins() == 7'b0110000, "R1 idle after reset", 32'(pins()), 32'h30);

      for (int i = 0; i < NV; i++) run_vec(VECS[i]);

      // R11: unknown kind codes are not accepted
      for (int k = 6; k < 8; k++) begin
         @(negedge clk);
         req_valid = 1'b1; req_kind = 3'(k); req_addr = 16'h7777;
         @(negedge clk);
         chk(!busy && !ale, "R11 unknown kind ignored", 32'({busy, ale}), 32'h0);
         req_valid = 1'b0;
      end

      // R2: request during a running cycle is dropped
      @(negedge clk);
      req_valid = 1'b1; req_kind = 3'd0; req_addr = 16'h1000; req_fetch_len = 3'd6;
      @(negedge clk);                     // T1
      req_kind = 3'd2; req_addr = 16'h2222; req_wdata = 8'h44;
      @(negedge clk); @(negedge clk);     // T3
      req_valid = 1'b0;
      @(negedge clk); @(negedge clk);     // T5
      chk(addr_out == 16'h1000, "R2 address unchanged by busy request",
          32'(addr_out), 32'h1000);
      chk(wr_n && busy, "R2 R10 no write strobe in T5", 32'({wr_n, busy}), 32'h3);
      @(negedge clk); @(negedge clk);     // done clock
      chk(done, "R8 fetch of 6 ends on time", 32'(done), 32'h1);
      @(negedge clk);
      chk(!busy && !ale, "R2 dropped request left no cycle", 32'({busy, ale}), 32'h0);

      // R9: back-to-back, request held into the done clock
      @(negedge clk);
      req_valid = 1'b1; req_kind = 3'd1; req_addr = 16'h4000;
      @(negedge clk);                     // T1
      req_kind = 3'd4; req_addr = 16'hBEEF; req_wdata = 8'h3C;
      @(negedge clk); @(negedge clk);     // T3 (last)
      chk(busy && !ale, "R2 held request waits while busy", 32'({busy, ale}), 32'h2);
      @(negedge clk);                     // done clock
      chk(done && !busy && !ale, "R9 done clock before new T1",
          32'({done, busy, ale}), 32'h4);
      @(negedge clk);                     // new T1
      req_valid = 1'b0;
      chk(ale && io_m && addr_out == 16'hBEEF, "R9 R4 back-to-back start",
          32'({ale, io_m, addr_out}), 32'h3BEEF);
      repeat (4) @(negedge clk);
      chk(!busy, "R8 back-to-back cycle finished", 32'(busy), 32'h0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule